// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash and turns a single start request into the complete bus traffic needed to program a run of bytes, erase one page, or erase the whole chip. For every operation it writes the multi-cycle unlock command stream, then reads the device repeatedly until the status bit reports completion, confirms the result with one more full-byte read, and signals done. A timeout counter, sized from the worst-case busy times of the device at the configured clock rate, ends any operation whose polling never succeeds and flags it as an error.

Program data is pulled one byte at a time through a request/valid handshake, so the source of the bytes can be a FIFO, a buffer or a register. The bus side is a simple single-cycle strobe master: a write strobe with address and data, and a read strobe whose returned byte is sampled on the following cycle. Strobe shaping and electrical timing are left to the bus adapter behind it.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A program byte is issued as four write strobes in this order: address 0x5555 data 0xAA, address 0x2AAA data 0x55, address 0x5555 data 0xA0, then the target address with the byte to program.
- R2: A chip erase (mode_i = 2) is issued as six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R3: A page erase (mode_i = 1) uses the same first five writes as R2 and ends with data 0x50 written to addr_i.
- R4: In program mode (mode_i = 0) dreq_o is raised once before each byte and a byte is taken from din_i in the cycle where dreq_o and dvalid_i are both high; dreq_o never rises for an erase.
- R5: After the last command write the block issues read strobes at the poll address (the byte address for a program, addr_i for an erase); bus_rdata_i is taken the cycle after bus_rd_o, and polling continues until its bit 7 equals bit 7 of the expected byte (the programmed data, or 0xFF for an erase).
- R6: After bit 7 matches, one further read is made; only if all eight bits equal the expected byte does the step pass, otherwise polling resumes.
- R7: A program of len_i bytes writes addresses addr_i to addr_i+len_i-1 in ascending order, each byte started only after the previous one passed.
- R8: A timeout counter is loaded at the last command write of each step with the limit for the mode (50 us program, 25 ms page erase, 100 ms chip erase at CLK_KHZ); a poll or verify failure after it has run out ends the operation with err_o = 1 and no further bus writes.
- R9: done_o is a one-cycle pulse after which busy_o is low; err_o is high only together with done_o.
- R10: start_i is ignored while busy_o is high.
- R11: A program with len_i = 0 completes with err_o = 0 and no bus strobes; mode_i = 3 completes with err_o = 1 and no bus strobes.
- R12: After reset and while idle, busy_o, done_o, dreq_o, bus_wr_o and bus_rd_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mode_i | input | 2 | 0 program, 1 page erase, 2 chip erase, 3 reserved |
| addr_i | input | ADDR_W | First program address or an address inside the erase target |
| len_i | input | LEN_W | Number of bytes to program |
| dreq_o | output | 1 | Next program byte requested |
| dvalid_i | input | 1 | din_i carries the requested byte |
| din_i | input | 8 | Program byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or reserved mode, valid with done_o |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data, valid the cycle after bus_rd_o |

## Verification
The assertions watch, on every cycle, that read and write strobes never coincide, that every command burst opens with the 0xAA unlock write at 0x5555, that the byte request appears only in program mode, that the operation settings stay fixed while busy, that the timeout counter behaves after each load, and that done and error pulses line up with the fall of busy. The exact unlock streams, the ascending byte addresses, the number of poll and verify reads under busy and corrupted responses, and the timeout abort can only be shown by the bench's scenarios against its behavioural flash model.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_PAGE = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CMD, S_PRD, S_PWAIT, S_VRD, S_VWAIT, S_DONE
  } st_e;

  localparam logic [14:0] UNLK_A = 15'h5555;
  localparam logic [14:0] UNLK_B = 15'h2AAA;

  localparam logic [BYTE_W-1:0] C_AA   = 8'hAA;
  localparam logic [BYTE_W-1:0] C_55   = 8'h55;
  localparam logic [BYTE_W-1:0] C_80   = 8'h80;
  localparam logic [BYTE_W-1:0] C_A0   = 8'hA0;
  localparam logic [BYTE_W-1:0] C_CHIP = 8'h10;
  localparam logic [BYTE_W-1:0] C_PAGE = 8'h50;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  op_e               op_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLK_A);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLK_B);

  always_comb begin
    addr_o = A1;
    data_o = C_AA;
    if (op_i == OP_PROG) begin
      last_o = (step_i == 3'd3);
      case (step_i)
        3'd0:    begin addr_o = A1;    data_o = C_AA;    end
        3'd1:    begin addr_o = A2;    data_o = C_55;    end
        3'd2:    begin addr_o = A1;    data_o = C_A0;    end
        default: begin addr_o = tgt_i; data_o = wbyte_i; end
      endcase
    end else begin
      last_o = (step_i == 3'd5);
      case (step_i)
        3'd0:    begin addr_o = A1; data_o = C_AA; end
        3'd1:    begin addr_o = A2; data_o = C_55; end
        3'd2:    begin addr_o = A1; data_o = C_80; end
        3'd3:    begin addr_o = A1; data_o = C_AA; end
        3'd4:    begin addr_o = A2; data_o = C_55; end
        default: begin
          // page erase targets any address in the page; chip erase the unlock address
          addr_o = (op_i == OP_PAGE) ? tgt_i : A1;
          data_o = (op_i == OP_PAGE) ? C_PAGE : C_CHIP;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int TMO_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= limit_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_load_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (limit_i != '0) |=> !expired_o);
  p_expired_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !load_i |=> expired_o);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LEN_W   = 17,
  parameter int CLK_KHZ = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              dreq_o,
  input  logic              dvalid_i,
  input  logic [7:0]        din_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i
);
  // worst-case busy windows in clock cycles
  localparam int PROG_TMO = (CLK_KHZ * 50 + 999) / 1000;
  localparam int PAGE_TMO = CLK_KHZ * 25;
  localparam int CHIP_TMO = CLK_KHZ * 100;
  localparam int TMO_W    = $clog2(CHIP_TMO + 1);

  st_e               state_q;
  op_e               op_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic [2:0]        step_q;
  logic              err_q;

  logic [ADDR_W-1:0] seq_addr;
  logic [BYTE_W-1:0] seq_data;
  logic              seq_last;
  logic              tmo_load, tmo_exp;
  logic [TMO_W-1:0]  tmo_lim;
  logic [BYTE_W-1:0] exp_byte;
  op_e               mode_op;

  assign mode_op = op_e'(mode_i);

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .op_i   (op_q),
    .step_i (step_q),
    .tgt_i  (cur_addr_q),
    .wbyte_i(wbyte_q),
    .addr_o (seq_addr),
    .data_o (seq_data),
    .last_o (seq_last)
  );

  always_comb begin
    case (op_q)
      OP_PROG: tmo_lim = TMO_W'(PROG_TMO);
      OP_PAGE: tmo_lim = TMO_W'(PAGE_TMO);
      default: tmo_lim = TMO_W'(CHIP_TMO);
    endcase
  end

  assign tmo_load = (state_q == S_CMD) && seq_last;

  flash_poll_timer #(.TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmo_load),
    .limit_i  (tmo_lim),
    .expired_o(tmo_exp)
  );

  assign exp_byte = (op_q == OP_PROG) ? wbyte_q : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_PROG;
      cur_addr_q <= '0;
      remain_q   <= '0;
      wbyte_q    <= '0;
      step_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q       <= mode_op;
          cur_addr_q <= addr_i;
          remain_q   <= len_i;
          step_q     <= '0;
          err_q      <= 1'b0;
          if (mode_op == OP_RSVD) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else if (mode_op == OP_PROG) begin
            state_q <= (len_i == '0) ? S_DONE : S_FETCH;
          end else begin
            state_q <= S_CMD;
          end
        end
        S_FETCH: if (dvalid_i) begin
          wbyte_q <= din_i;
          step_q  <= '0;
          state_q <= S_CMD;
        end
        S_CMD: begin
          if (seq_last) state_q <= S_PRD;
          else          step_q  <= step_q + 3'd1;
        end
        S_PRD: state_q <= S_PWAIT;
        S_PWAIT: begin
          if (bus_rdata_i[7] == exp_byte[7]) state_q <= S_VRD;
          else if (tmo_exp) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else state_q <= S_PRD;
        end
        S_VRD: state_q <= S_VWAIT;
        S_VWAIT: begin
          if (bus_rdata_i == exp_byte) begin
            if (op_q == OP_PROG && remain_q != LEN_W'(1)) begin
              remain_q   <= remain_q - 1'b1;
              cur_addr_q <= cur_addr_q + 1'b1;
              state_q    <= S_FETCH;
            end else begin
              state_q <= S_DONE;
            end
          end else if (tmo_exp) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            // status bit settled before the rest of the byte: poll again
            state_q <= S_PRD;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign err_o       = done_o && err_q;
  assign dreq_o      = (state_q == S_FETCH);
  assign bus_wr_o    = (state_q == S_CMD);
  assign bus_rd_o    = (state_q == S_PRD) || (state_q == S_VRD);
  assign bus_addr_o  = (state_q == S_CMD) ? seq_addr : cur_addr_q;
  assign bus_wdata_o = seq_data;

  p_excl_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));
  p_unlock_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o && !$past(bus_wr_o) |-> (bus_addr_o == ADDR_W'(UNLK_A)) && (bus_wdata_o == C_AA));
  p_dreq_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (op_q == OP_PROG));
  p_err_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  p_hold_cfg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(op_q));
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_wr_o && !bus_rd_o && !dreq_o);
endmodule

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;
  localparam int ADDR_W  = 17;
  localparam int LEN_W   = 17;
  localparam int CLK_KHZ = 200; // program limit 10 cycles, page 5000, chip 20000
  localparam int WD_CYC  = 150000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [16:0] addr;
    logic [16:0] len;
    int          busy;
    int          glit;
    logic        err;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 17'h00100, 17'd0, 3,     0, 1'b0},
    '{2'd0, 17'h00010, 17'd4, 2,     0, 1'b0},
    '{2'd0, 17'h000F0, 17'd3, 0,     1, 1'b0},
    '{2'd1, 17'h00050, 17'd0, 5,     0, 1'b0},
    '{2'd0, 17'h001F0, 17'd2, 1,     2, 1'b0},
    '{2'd0, 17'h00020, 17'd1, 1000,  0, 1'b1},
    '{2'd1, 17'h00080, 17'd0, 30000, 0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [LEN_W-1:0] len = '0;
  logic dvalid = 1'b0;
  logic [7:0] din = '0;
  logic dreq_o, busy_o, done_o, err_o, bus_wr_o, bus_rd_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic [7:0] rdata;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLK_KHZ(CLK_KHZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
    .len_i(len), .dreq_o(dreq_o), .dvalid_i(dvalid), .din_i(din), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(rdata)
  );

  // behavioural flash model and bus log
  logic [7:0] mem [512];
  logic [ADDR_W-1:0] log_a [64];
  logic [7:0] log_d [64];
  int wtot, rtot, hs, busy_cnt, glit_cnt;
  int cfg_busy = 0;
  int cfg_glit = 0;
  logic [7:0] h1, h2, h3;
  logic tog;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'hFF;
      wtot <= 0; rtot <= 0; hs <= 0; busy_cnt <= 0; glit_cnt <= 0;
      h1 <= '0; h2 <= '0; h3 <= '0; tog <= 1'b0; rdata <= '0;
    end else begin
      if (dreq_o && dvalid) hs <= hs + 1;
      if (bus_wr_o) begin
        log_a[wtot % 64] <= bus_addr_o;
        log_d[wtot % 64] <= bus_wdata_o;
        wtot <= wtot + 1;
        h1 <= bus_wdata_o; h2 <= h1; h3 <= h2;
        if (h1 == 8'hA0 && h2 == 8'h55 && h3 == 8'hAA) begin
          mem[bus_addr_o[8:0]] <= mem[bus_addr_o[8:0]] & bus_wdata_o;
          busy_cnt <= cfg_busy; glit_cnt <= cfg_glit;
        end else if (h1 == 8'h55 && h2 == 8'hAA && h3 == 8'h80 &&
                     (bus_wdata_o == 8'h10 || bus_wdata_o == 8'h50)) begin
          for (int i = 0; i < 512; i++) mem[i] <= 8'hFF;
          busy_cnt <= cfg_busy; glit_cnt <= cfg_glit;
        end
      end
      if (bus_rd_o) begin
        rtot <= rtot + 1;
        if (busy_cnt > 0) begin
          rdata <= {~mem[bus_addr_o[8:0]][7], tog, mem[bus_addr_o[8:0]][5:0]};
          tog <= ~tog;
          busy_cnt <= busy_cnt - 1;
        end else if (glit_cnt > 0) begin
          rdata <= {mem[bus_addr_o[8:0]][7], ~mem[bus_addr_o[8:0]][6:0]};
          glit_cnt <= glit_cnt - 1;
        end else begin
          rdata <= mem[bus_addr_o[8:0]];
        end
      end
    end
  end

  function automatic logic [7:0] dat(input logic [16:0] a);
    return (a[7:0] * 8'd37) ^ 8'hC3;
  endfunction

  function automatic logic [24:0] seq_ent(input logic [1:0] m, input int j,
                                          input logic [16:0] a, input logic [7:0] d);
    if (m == 2'd0) begin
      case (j)
        0: return {17'h05555, 8'hAA};
        1: return {17'h02AAA, 8'h55};
        2: return {17'h05555, 8'hA0};
        default: return {a, d};
      endcase
    end
    case (j)
      0, 3: return {17'h05555, 8'hAA};
      1, 4: return {17'h02AAA, 8'h55};
      2: return {17'h05555, 8'h80};
      default: return (m == 2'd1) ? {a, 8'h50} : {17'h05555, 8'h10};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_seq(input int w0, input logic [1:0] m, input logic [16:0] a,
                         input logic [7:0] d, input string tag);
    int n;
    bit ok;
    logic [24:0] act, exp, fa, fe;
    n = (m == 2'd0) ? 4 : 6;
    ok = 1'b1; fa = '0; fe = '0;
    for (int j = 0; j < n; j++) begin
      act = {log_a[(w0 + j) % 64], log_d[(w0 + j) % 64]};
      exp = seq_ent(m, j, a, d);
      if (ok && act != exp) begin ok = 1'b0; fa = act; fe = exp; end
    end
    chk(ok, tag, fa, fe);
  endtask

  task automatic run_op(input logic [1:0] m, input logic [16:0] a, input logic [16:0] n,
                        input int b, input int g, input bit poke, output bit e);
    int k, it;
    cfg_busy = b; cfg_glit = g;
    @(negedge clk);
    start = 1'b1; mode = m; addr = a; len = n;
    @(negedge clk);
    start = 1'b0;
    k = 0; it = 0;
    while (!done_o && it < 60000) begin
      if (dreq_o) begin dvalid = 1'b1; din = dat(17'(a + 17'(k))); k++; end
      else dvalid = 1'b0;
      start = (poke && it == 3);
      if (poke && it == 3) mode = 2'd2;
      @(negedge clk);
      it++;
    end
    dvalid = 1'b0; start = 1'b0;
    chk(done_o == 1'b1, "R9 done seen", done_o, 1);
    e = err_o;
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 done pulse then idle", {done_o, busy_o}, 0);
  endtask

  initial begin
    #(WD_CYC * 4);
    total++; fails++;
    $display("FAIL watchdog R9: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit e;
    int w0, r0, h0, per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, dreq_o, bus_wr_o, bus_rd_o} == 5'b0, "R12 reset state",
        {busy_o, done_o, dreq_o, bus_wr_o, bus_rd_o}, 0);

    for (int i = 0; i < NV; i++) begin
      w0 = wtot; r0 = rtot; h0 = hs;
      run_op(VECS[i].mode, VECS[i].addr, VECS[i].len, VECS[i].busy, VECS[i].glit, 1'b0, e);
      chk(e == VECS[i].err, "R8 error flag", e, VECS[i].err);
      per = VECS[i].busy + VECS[i].glit + ((VECS[i].glit % 2) ? 1 : 2);
      if (VECS[i].err) begin
        chk(wtot - w0 == ((VECS[i].mode == 2'd0) ? 4 : 6), "R8 no writes after timeout",
            wtot - w0, (VECS[i].mode == 2'd0) ? 4 : 6);
      end else if (VECS[i].mode == 2'd0) begin
        chk(hs - h0 == int'(VECS[i].len), "R4 one request per byte", hs - h0, VECS[i].len);
        chk(wtot - w0 == 4 * int'(VECS[i].len), "R7 write count", wtot - w0, 4 * VECS[i].len);
        for (int k = 0; k < int'(VECS[i].len); k++) begin
          chk_seq(w0 + 4 * k, 2'd0, 17'(VECS[i].addr + 17'(k)),
                  dat(17'(VECS[i].addr + 17'(k))), "R1 program stream");
          chk(mem[9'(VECS[i].addr + 17'(k))] == dat(17'(VECS[i].addr + 17'(k))),
              "R7 byte programmed", mem[9'(VECS[i].addr + 17'(k))], dat(17'(VECS[i].addr + 17'(k))));
        end
        chk(rtot - r0 == per * int'(VECS[i].len), "R5 R6 poll and verify reads",
            rtot - r0, per * VECS[i].len);
      end else begin
        chk(hs - h0 == 0, "R4 no request in erase", hs - h0, 0);
        chk(wtot - w0 == 6, "R2 R3 erase write count", wtot - w0, 6);
        chk_seq(w0, VECS[i].mode, VECS[i].addr, 8'h00,
                (VECS[i].mode == 2'd1) ? "R3 page erase stream" : "R2 chip erase stream");
        chk(rtot - r0 == per, "R5 erase poll reads", rtot - r0, per);
        chk(mem[VECS[i].addr[8:0]] == 8'hFF, "R6 erased byte", mem[VECS[i].addr[8:0]], 8'hFF);
      end
    end

    // R11: zero-length program
    w0 = wtot; r0 = rtot;
    run_op(2'd0, 17'h00030, 17'd0, 0, 0, 1'b0, e);
    chk(e == 1'b0, "R11 zero length no error", e, 0);
    chk((wtot - w0) + (rtot - r0) == 0, "R11 zero length no strobes", (wtot - w0) + (rtot - r0), 0);

    // R11: reserved mode
    w0 = wtot; r0 = rtot;
    run_op(2'd3, 17'h00030, 17'd1, 0, 0, 1'b0, e);
    chk(e == 1'b1, "R11 reserved mode error", e, 1);
    chk((wtot - w0) + (rtot - r0) == 0, "R11 reserved mode no strobes", (wtot - w0) + (rtot - r0), 0);

    // R10: start pulse during a program is ignored
    w0 = wtot;
    run_op(2'd0, 17'h00040, 17'd1, 5, 0, 1'b1, e);
    chk(e == 1'b0, "R10 program unaffected", e, 0);
    chk(wtot - w0 == 4, "R10 no extra command", wtot - w0, 4);
    chk_seq(w0, 2'd0, 17'h00040, dat(17'h00040), "R10 stream intact");
    repeat (10) @(negedge clk);
    chk(!busy_o && (wtot - w0 == 4), "R10 stays idle", {busy_o, 8'(wtot - w0)}, 4);
    chk(mem[9'h040] == dat(17'h00040), "R10 byte programmed", mem[9'h040], dat(17'h00040));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule